// File: doc/BRIEF.md
# Packed Decimal Byte Adder-Subtractor

This combinational unit does decimal arithmetic on a byte that holds two packed decimal digits, one 4-bit binary code per digit (0000 to 1001, tens digit in bits 7:4, units digit in bits 3:0). A 2-bit operation code picks one of three operations. Add forms `a + b + xin`. Subtract forms `a - b - xin`. Negate forms `0 - a - xin`, which gives the ten's complement of `a` when `xin` is 0 and the nine's complement when `xin` is 1. Each digit is corrected separately, and the digit carry or borrow ripples from the units digit to the tens digit.

The extend flag is both the incoming carry or borrow and the outgoing one. The zero flag can only be cleared, never set. Together these let software chain the unit over several bytes, from the least significant byte upward, to do arithmetic on long decimal numbers. After the last byte, the zero flag tells whether the whole number is zero. The carry output always equals the extend output. The negative and overflow outputs have no defined meaning and are driven low. The digit count is a parameter (default 2, one byte), and the operand width is derived from it.

Top module: `bcd_byte_alu`

## Requirements
- R1: With `op` = 2'b00 (add), `res` holds the low two decimal digits of `a + b + xin`, and `xout` is 1 exactly when that sum is above 99 (for example 99 + 99 + 1 gives 99 with `xout` = 1, and 15 + 45 + 0 gives 60 with `xout` = 0).
- R2: With `op` = 2'b01 (subtract), `res` holds `a - b - xin` modulo 100, and `xout` is 1 exactly when the true difference is below zero (for example 50 - 25 - 1 gives 24 with `xout` = 0, and 50 - 99 - 0 gives 51 with `xout` = 1).
- R3: With `op[1]` = 1 (negate; 2'b10 and 2'b11 both select it), `res` holds `0 - a - xin` modulo 100, and `b` has no effect on any output (45 with `xin` = 0 gives 55, and 45 with `xin` = 1 gives 54).
- R4: Negate of 00 with `xin` = 0 gives 00 with `xout` = `cout` = 0. Every other negate gives `xout` = `cout` = 1.
- R5: `cout` always equals `xout`.
- R6: `zout` is 0 when `res` is non-zero, and equals `zin` when `res` is zero.
- R7: `nout` and `vout` are always 0.
- R8: For valid decimal inputs, every 4-bit digit of `res` is at most 9.
- R9: Feeding `xout` and `zout` of the low byte into `xin` and `zin` of the next byte gives correct multi-byte decimal sums, differences and a correct whole-number zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op   | input  | 2 | Operation: 00 add, 01 subtract, 1x negate |
| a    | input  | 8 | Destination operand, packed decimal |
| b    | input  | 8 | Source operand, packed decimal (not used by negate) |
| xin  | input  | 1 | Incoming extend (carry or borrow in) |
| zin  | input  | 1 | Incoming zero flag |
| res  | output | 8 | Packed decimal result |
| xout | output | 1 | Outgoing extend (carry or borrow out) |
| cout | output | 1 | Carry flag, a copy of the extend |
| zout | output | 1 | Sticky zero flag |
| nout | output | 1 | Negative flag, always 0 |
| vout | output | 1 | Overflow flag, always 0 |

## Verification
The bench sweeps every valid operand pair with both extend values for add and subtract. This catches a design whose correction adds 6 only when the binary digit sum is above 9, because such a design gets sums of 16 to 19 wrong (8 + 9 would come out as 11 instead of 17). The sweep also catches a subtractor that never subtracts 6 after a borrow. Negate is checked at 00 with both extend values, since a design that always raises the borrow would report a borrow for zero. The sticky zero flag is checked with a zero result and `zin` = 0, where a design that simply detects zero would wrongly report 1. A two-byte chain across 9999 and 0000 confirms that the carry, the borrow and the zero flag all propagate from byte to byte.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
   localparam int unsigned NIB_W = 4;
   localparam logic [1:0] OPC_ADD = 2'b00;
   localparam logic [1:0] OPC_SUB = 2'b01;
   localparam logic [1:0] OPC_NEG = 2'b10;

   typedef struct packed {
      logic x;
      logic c;
      logic z;
      logic n;
      logic v;
   } bcd_flags_t;
endpackage

// File: rtl/bcd_operand_mux.sv
module bcd_operand_mux #(
   parameter int unsigned W = 8
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lhs,
   output logic [W-1:0] rhs,
   output logic         sub
);
   // negate is a subtract from zero; op[1] alone selects it
   always_comb begin
      if (op[1]) begin
         lhs = '0;
         rhs = a;
         sub = 1'b1;
      end else begin
         lhs = a;
         rhs = b;
         sub = op[0];
      end
   end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
   import bcd_alu_pkg::*;
(
   input  logic [NIB_W-1:0] l,
   input  logic [NIB_W-1:0] r,
   input  logic             ci,
   input  logic             sub,
   output logic [NIB_W-1:0] d,
   output logic             co
);
   logic [NIB_W:0] raw;

   always_comb begin
      if (!sub) begin
         raw = {1'b0, l} + {1'b0, r} + {{NIB_W{1'b0}}, ci};
         // binary digit sum beyond nine (incl. nibble carry) needs +6
         if (raw > 5'd9) begin
            d  = raw[NIB_W-1:0] + 4'd6;
            co = 1'b1;
         end else begin
            d  = raw[NIB_W-1:0];
            co = 1'b0;
         end
      end else begin
         raw = {1'b0, l} - {1'b0, r} - {{NIB_W{1'b0}}, ci};
         // a borrow leaves the digit 6 too high in the 16-wrap
         if (raw[NIB_W]) begin
            d  = raw[NIB_W-1:0] - 4'd6;
            co = 1'b1;
         end else begin
            d  = raw[NIB_W-1:0];
            co = 1'b0;
         end
      end
   end
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit
   import bcd_alu_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] res,
   input  logic         carry,
   input  logic         zin,
   output bcd_flags_t   flags
);
   always_comb begin
      flags.x = carry;
      flags.c = carry;
      flags.z = zin & ~(|res);
      flags.n = 1'b0;
      flags.v = 1'b0;
   end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
   import bcd_alu_pkg::*;
#(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = DIGITS * NIB_W
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         xin,
   input  logic         zin,
   output logic [W-1:0] res,
   output logic         xout,
   output logic         cout,
   output logic         zout,
   output logic         nout,
   output logic         vout
);
   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("bcd_byte_alu: DIGITS must be at least 1");
      end
   endgenerate

   logic [W-1:0]  lhs, rhs;
   logic          sub;
   logic [DIGITS:0] chain;
   bcd_flags_t    fl;

   bcd_operand_mux #(.W(W)) u_mux (
      .op(op), .a(a), .b(b), .lhs(lhs), .rhs(rhs), .sub(sub)
   );

   assign chain[0] = xin;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_digit
         bcd_digit_cell u_cell (
            .l  (lhs[g*NIB_W +: NIB_W]),
            .r  (rhs[g*NIB_W +: NIB_W]),
            .ci (chain[g]),
            .sub(sub),
            .d  (res[g*NIB_W +: NIB_W]),
            .co (chain[g+1])
         );
      end
   endgenerate

   bcd_flag_unit #(.W(W)) u_flags (
      .res(res), .carry(chain[DIGITS]), .zin(zin), .flags(fl)
   );

   assign xout = fl.x;
   assign cout = fl.c;
   assign zout = fl.z;
   assign nout = fl.n;
   assign vout = fl.v;
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk #(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = DIGITS * 4
) (
   input logic [1:0]   op,
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic         xin,
   input logic         zin,
   input logic [W-1:0] res,
   input logic         xout,
   input logic         cout,
   input logic         zout,
   input logic         nout,
   input logic         vout
);
   function automatic longint dec_val(input logic [W-1:0] v);
      longint acc = 0;
      for (int i = DIGITS - 1; i >= 0; i--) acc = acc * 10 + longint'(v[i*4 +: 4]);
      return acc;
   endfunction

   function automatic bit is_dec(input logic [W-1:0] v);
      bit ok = 1'b1;
      for (int i = 0; i < DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   function automatic longint modulus();
      longint m = 1;
      for (int i = 0; i < DIGITS; i++) m = m * 10;
      return m;
   endfunction

   longint ra, rb, rr, xi, xo, m;
   bit     valid;

   always_comb begin
      ra    = dec_val(a);
      rb    = dec_val(b);
      rr    = dec_val(res);
      xi    = longint'(xin);
      xo    = longint'(xout);
      m     = modulus();
      valid = is_dec(a) && is_dec(b);

      assert_x_eq_c_R5: assert (cout == xout);
      assert_nv_low_R7: assert (!nout && !vout);
      if (|res) begin
         assert_z_clear_R6: assert (!zout);
      end else begin
         assert_z_keep_R6: assert (zout == zin);
      end
      if (valid) begin
         assert_digits_ok_R8: assert (is_dec(res));
         if (op == 2'b00) begin
            assert_add_sum_R1: assert (rr + xo * m == ra + rb + xi);
         end else if (op == 2'b01) begin
            assert_sub_diff_R2: assert (rr - xo * m == ra - rb - xi);
         end else begin
            assert_neg_diff_R3: assert (rr - xo * m == 0 - ra - xi);
            assert_neg_borrow_R4: assert (xout == ((ra != 0) || xin));
         end
      end
   end
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.DIGITS(DIGITS)) u_chk (
   .op(op), .a(a), .b(b), .xin(xin), .zin(zin), .res(res),
   .xout(xout), .cout(cout), .zout(zout), .nout(nout), .vout(vout)
);

// File: tb/tb_bcd_byte_alu.sv
module tb_bcd_byte_alu;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [1:0] op;
   logic [7:0] a, b, res;
   logic xin, zin, xout, cout, zout, nout, vout;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   bcd_byte_alu dut (
      .op(op), .a(a), .b(b), .xin(xin), .zin(zin), .res(res),
      .xout(xout), .cout(cout), .zout(zout), .nout(nout), .vout(vout)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int from_bcd(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   task automatic apply(input logic [1:0] o, input int av, input int bv,
                        input logic x, input logic z);
      op = o; a = to_bcd(av); b = to_bcd(bv); xin = x; zin = z;
      #1;
   endtask

   task automatic expect_out(input string req, input int er, input logic ex,
                             input logic ez);
      checks++;
      if (res !== to_bcd(er) || xout !== ex || cout !== ex || zout !== ez ||
          nout !== 1'b0 || vout !== 1'b0) begin
         errors++;
         $display("FAIL %s: res=%h x=%b c=%b z=%b n=%b v=%b expected res=%h x=%b c=%b z=%b n=0 v=0",
                  req, res, xout, cout, zout, nout, vout, to_bcd(er), ex, ex, ez);
      end
   endtask

   // reference model from the requirements
   task automatic ref_op(input logic [1:0] o, input int av, input int bv,
                         input logic x, output int r, output logic c);
      int t;
      if (o == 2'b00) begin
         t = av + bv + int'(x); c = (t > 99); r = t % 100;
      end else begin
         t = (o == 2'b01) ? (av - bv - int'(x)) : (0 - av - int'(x));
         c = (t < 0); r = (t + 100) % 100;
      end
   endtask

   task automatic t_reset_state();
      apply(2'b00, 0, 0, 1'b0, 1'b0);
      expect_out("R6 idle zero-in", 0, 1'b0, 1'b0);
   endtask

   task automatic t_add_cases();
      apply(2'b00, 15, 45, 1'b0, 1'b1); expect_out("R1 15+45+0", 60, 1'b0, 1'b0);
      apply(2'b00, 99, 99, 1'b1, 1'b1); expect_out("R1 99+99+1", 99, 1'b1, 1'b0);
      apply(2'b00, 8, 9, 1'b0, 1'b1);   expect_out("R1 R8 8+9 nibble carry", 17, 1'b0, 1'b0);
      apply(2'b00, 50, 50, 1'b0, 1'b1); expect_out("R1 R6 50+50 zero kept", 0, 1'b1, 1'b1);
   endtask

   task automatic t_sub_cases();
      apply(2'b01, 50, 25, 1'b1, 1'b0); expect_out("R2 50-25-1", 24, 1'b0, 1'b0);
      apply(2'b01, 50, 99, 1'b0, 1'b0); expect_out("R2 50-99-0", 51, 1'b1, 1'b0);
      apply(2'b01, 0, 0, 1'b1, 1'b1);   expect_out("R2 0-0-1", 99, 1'b1, 1'b0);
      apply(2'b01, 37, 37, 1'b0, 1'b0); expect_out("R6 zero result zin=0", 0, 1'b0, 1'b0);
   endtask

   task automatic t_negate_cases();
      apply(2'b10, 45, 0, 1'b0, 1'b0);  expect_out("R3 tens complement", 55, 1'b1, 1'b0);
      apply(2'b10, 45, 0, 1'b1, 1'b0);  expect_out("R3 nines complement", 54, 1'b1, 1'b0);
      apply(2'b10, 0, 0, 1'b0, 1'b1);   expect_out("R4 negate 00 x=0", 0, 1'b0, 1'b1);
      apply(2'b10, 0, 0, 1'b1, 1'b1);   expect_out("R4 negate 00 x=1", 99, 1'b1, 1'b0);
      apply(2'b11, 45, 77, 1'b0, 1'b0); expect_out("R3 op 11 ignores b", 55, 1'b1, 1'b0);
      apply(2'b10, 45, 99, 1'b1, 1'b0); expect_out("R3 b ignored", 54, 1'b1, 1'b0);
   endtask

   task automatic t_sweep();
      int r; logic c; logic ez;
      for (int o = 0; o < 3; o++)
         for (int av = 0; av < 100; av++)
            for (int bv = 0; bv < 100; bv++)
               for (int x = 0; x < 2; x++) begin
                  if (o == 2 && bv != 0) continue;
                  ref_op(2'(o), av, bv, 1'(x), r, c);
                  apply(2'(o), av, bv, 1'(x), 1'b1);
                  ez = (r == 0);
                  expect_out(o == 0 ? "R1 R5 R8 sweep" : (o == 1 ? "R2 R5 R8 sweep" : "R3 R4 sweep"),
                             r, c, ez);
               end
   endtask

   task automatic t_chain(input logic [1:0] o, input int av, input int bv,
                          input int er, input logic ex, input logic ez, input string req);
      logic xm, zm; int lo, hi;
      apply(o, av % 100, bv % 100, o == 2'b00 ? 1'b0 : 1'b0, 1'b1);
      lo = from_bcd(res); xm = xout; zm = zout;
      apply(o, av / 100, bv / 100, xm, zm);
      hi = from_bcd(res);
      checks++;
      if (hi * 100 + lo != er || xout !== ex || zout !== ez) begin
         errors++;
         $display("FAIL %s: value=%0d x=%b z=%b expected value=%0d x=%b z=%b",
                  req, hi * 100 + lo, xout, zout, er, ex, ez);
      end
   endtask

   initial begin
      op = 2'b00; a = '0; b = '0; xin = 1'b0; zin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_add_cases();
      t_sub_cases();
      t_negate_cases();
      t_chain(2'b00, 1234, 8766, 0, 1'b1, 1'b1, "R9 chain add 1234+8766");
      t_chain(2'b00, 1234, 4321, 5555, 1'b0, 1'b0, "R9 chain add 1234+4321");
      t_chain(2'b01, 0, 1, 9999, 1'b1, 1'b0, "R9 chain sub 0-1");
      t_chain(2'b01, 4200, 4200, 0, 1'b0, 1'b1, "R9 chain sub equal");
      t_chain(2'b10, 100, 0, 9900, 1'b1, 1'b0, "R9 chain negate 0100");
      t_sweep();
      done = 1'b1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         done = 1'b1;
      end
   end

   initial begin
      wait (done);
      #10;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule